// File: doc/BRIEF.md
# Lamp Ballast Start-up Sequencer

This block controls a half-bridge lamp ballast from a numerically controlled oscillator. Once the digitized supply code is judged healthy, it heats the lamp electrodes at a high fixed switching frequency. It then ramps the frequency linearly down to the ignition value and stays there while the lamp burns. The two outputs are complementary enables for the low-side and high-side gate drivers. Each half period starts with a programmable dead slot in which neither output conducts.

Two digital enables protect the lamp. The fault input puts the block in a latched shutdown with both gates low and the oscillator stopped, the same as the undervoltage state. The restart input clears that latch and runs the whole start-up sequence again, from any powered phase. Both enables must stay high for a minimum number of clock cycles before they are accepted. The supply monitor uses two programmable thresholds with hysteresis.

Top module: `ballast_seq`

## Requirements
- R1: Out of reset, and while the supply code has never reached the turn-on threshold, the phase output reads off (code 0) and both gate outputs are low.
- R2: When a start occurs, the phase reads preheat (code 1) for exactly `preLen` clock cycles. During that time the accumulator advances by `fPreInc` each cycle, so the low-side period is 2^ACC_W / fPreInc cycles.
- R3: After preheat, the phase reads shift (code 2) for floor(preLen/10) cycles. During the shift the frequency word falls linearly from `fPreInc` toward `fIgnInc` and never leaves that range. When floor(preLen/10) is zero, the shift is skipped and the block goes straight to run.
- R4: After the shift, the phase reads run (code 3) and the block switches at `fIgnInc` until a fault, a restart or an undervoltage occurs.
- R5: The supply is judged valid when the code is at or above `supOnTh` and invalid when it is below `supOffTh`. A code between the two thresholds keeps the previous judgement. The cycle after the code falls below `supOffTh`, the phase is off.
- R6: An accepted fault enable moves any powered phase to fault (code 4). In fault both gates stay low, and fault persists after the input is released.
- R7: Fault is left only by an accepted restart enable, which leads to preheat, or by a supply cycle that goes below `supOffTh` (off) and then reaches `supOnTh` (preheat). If fault and restart are accepted in the same cycle, fault wins.
- R8: An accepted restart enable in preheat, shift or run re-enters preheat and restarts the sequence.
- R9: An enable is accepted only after it has stayed high for MIN_HIGH consecutive cycles. A shorter pulse has no effect. A held input is accepted once.
- R10: The low-side output conducts only in the first half of the accumulator cycle (MSB 0) and the high-side output only in the second half. Each half opens with `deadLen` cycles in which both outputs are low.
- R11: After every start, the low-side output is the first gate to go high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| faultIn | input | 1 | Fault enable, active high, latched shutdown |
| restartIn | input | 1 | Restart enable, active high |
| supCode | input | SUP_W | Digitized supply level |
| supOnTh | input | SUP_W | Supply turn-on threshold |
| supOffTh | input | SUP_W | Supply turn-off threshold |
| preLen | input | PRE_W | Preheat length in cycles |
| fPreInc | input | INC_W | Preheat frequency word (accumulator increment) |
| fIgnInc | input | INC_W | Ignition frequency word, below fPreInc |
| deadLen | input | DEAD_W | Dead slot length in cycles |
| lowGate | output | 1 | Low-side gate enable |
| highGate | output | 1 | High-side gate enable |
| phase | output | 3 | 0 off, 1 preheat, 2 shift, 3 run, 4 fault |

## Verification
A wrong sequencer state shows on the phase output in the same cycle it is entered. It also shows on the gates within one period: they either keep toggling in fault or off, or they switch at the wrong rate. A wrong timer value shows as a preheat or shift run length that differs from the programmed one. A wrong frequency word shows as a low-side period or conduction width that differs from 2^ACC_W divided by the word, measured over one full period. Errors in the enable filter show up at once: a short pulse changes the phase, or a long pulse fails to change it within a few cycles of the MIN_HIGH-th high cycle.

// File: rtl/ballast_pkg.sv
package ballast_pkg;
  typedef enum logic [2:0] {
    PH_OFF   = 3'd0,
    PH_PRE   = 3'd1,
    PH_SHIFT = 3'd2,
    PH_RUN   = 3'd3,
    PH_FAULT = 3'd4
  } phase_t;

  typedef struct packed {
    logic start;      // clear accumulator, load preheat word
    logic sweepInit;  // latch sweep step and remainder
    logic sweepStep;  // apply one sweep step
    logic loadIgn;    // force ignition word
    logic oscOn;      // accumulator running, gates allowed
  } osc_ctl_t;
endpackage

// File: rtl/ballast_enfilt.sv
module ballast_enfilt #(
  parameter int MIN_HIGH = 20
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic accept
);
  localparam int CW = $clog2(MIN_HIGH + 1);
  logic [CW-1:0] highCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) highCnt <= '0;
    else if (!din) highCnt <= '0;
    else if (highCnt != CW'(MIN_HIGH)) highCnt <= highCnt + 1'b1;
  end

  assign accept = din && (highCnt == CW'(MIN_HIGH - 1));

  // R9: a held input yields one acceptance only
  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !accept);
endmodule

// File: rtl/ballast_ctrl.sv
module ballast_ctrl
  import ballast_pkg::*;
#(
  parameter int SUP_W    = 8,
  parameter int PRE_W    = 20,
  parameter int MIN_HIGH = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             faultIn,
  input  logic             restartIn,
  input  logic [SUP_W-1:0] supCode,
  input  logic [SUP_W-1:0] supOnTh,
  input  logic [SUP_W-1:0] supOffTh,
  input  logic [PRE_W-1:0] preLen,
  output osc_ctl_t         ctl,
  output logic [PRE_W-1:0] shLen,
  output phase_t           phase
);
  logic [1:0] enRaw, enAcc;
  assign enRaw = {restartIn, faultIn};

  generate
    for (genvar i = 0; i < 2; i++) begin : g_filt
      ballast_enfilt #(.MIN_HIGH(MIN_HIGH)) u_filt (
        .clk(clk), .rstN(rstN), .din(enRaw[i]), .accept(enAcc[i]));
    end
  endgenerate

  logic supOk, supOkNext;
  assign supOkNext = supOk ? (supCode >= supOffTh) : (supCode >= supOnTh);
  assign shLen = preLen / PRE_W'(10);

  phase_t state, stateNext;
  logic [PRE_W-1:0] timer, timerNext;
  logic [PRE_W:0] timerInc;
  assign timerInc = {1'b0, timer} + 1'b1;

  always_comb begin
    stateNext = state;
    timerNext = timer;
    ctl = '0;
    ctl.oscOn = (state == PH_PRE) || (state == PH_SHIFT) || (state == PH_RUN);
    ctl.sweepStep = (state == PH_SHIFT);
    if (!supOkNext) begin
      stateNext = PH_OFF;
    end else if (state == PH_OFF) begin
      stateNext = PH_PRE; timerNext = '0; ctl.start = 1'b1;
    end else if (enAcc[0]) begin
      stateNext = PH_FAULT;
    end else if (enAcc[1]) begin
      stateNext = PH_PRE; timerNext = '0; ctl.start = 1'b1;
    end else begin
      case (state)
        PH_PRE: begin
          if (timerInc >= {1'b0, preLen}) begin
            timerNext = '0;
            if (shLen == '0) begin stateNext = PH_RUN; ctl.loadIgn = 1'b1; end
            else begin stateNext = PH_SHIFT; ctl.sweepInit = 1'b1; end
          end else timerNext = timerInc[PRE_W-1:0];
        end
        PH_SHIFT: begin
          if (timerInc >= {1'b0, shLen}) begin
            timerNext = '0; stateNext = PH_RUN; ctl.loadIgn = 1'b1;
          end else timerNext = timerInc[PRE_W-1:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      supOk <= 1'b0;
      state <= PH_OFF;
      timer <= '0;
    end else begin
      supOk <= supOkNext;
      state <= stateNext;
      timer <= timerNext;
    end
  end

  assign phase = state;

  // R8: accepted restart (without fault, supply valid) lands in preheat
  a_r8_restart_to_pre: assert property (@(posedge clk) disable iff (!rstN)
    (enAcc[1] && !enAcc[0] && supOkNext) |=> state == PH_PRE);
  // R7: fault wins over a simultaneous restart
  a_r7_fault_priority: assert property (@(posedge clk) disable iff (!rstN)
    (enAcc[0] && supOk && supOkNext && state != PH_OFF) |=> state == PH_FAULT);
endmodule

// File: rtl/ballast_osc.sv
module ballast_osc
  import ballast_pkg::*;
#(
  parameter int ACC_W  = 16,
  parameter int INC_W  = 16,
  parameter int PRE_W  = 20,
  parameter int DEAD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  osc_ctl_t          ctl,
  input  logic [INC_W-1:0]  fPreInc,
  input  logic [INC_W-1:0]  fIgnInc,
  input  logic [DEAD_W-1:0] deadLen,
  input  logic [PRE_W-1:0]  shLen,
  output logic              lowGate,
  output logic              highGate
);
  localparam int DW = (INC_W > PRE_W) ? INC_W : PRE_W;

  logic [ACC_W-1:0]  acc, accNext;
  logic [INC_W-1:0]  inc, stepQ;
  logic [PRE_W-1:0]  stepR;
  logic [PRE_W:0]    err, errSum, errNext;
  logic [DEAD_W-1:0] halfCnt;

  // sweep step and remainder over the shift length
  logic [DW-1:0] deltaW, divW;
  assign deltaW = DW'(fPreInc - fIgnInc);
  assign divW   = (shLen == '0) ? DW'(1) : DW'(shLen);

  logic          carry;
  logic [INC_W:0] decr, tryInc;
  logic [INC_W-1:0] stepInc;
  assign errSum  = err + {1'b0, stepR};
  assign carry   = errSum >= {1'b0, shLen};
  assign errNext = carry ? errSum - {1'b0, shLen} : errSum;
  assign decr    = {1'b0, stepQ} + {{INC_W{1'b0}}, carry};
  assign tryInc  = {1'b0, inc} - decr;
  assign stepInc = (tryInc[INC_W] || tryInc[INC_W-1:0] < fIgnInc) ? fIgnInc : tryInc[INC_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inc <= '0; stepQ <= '0; stepR <= '0; err <= '0;
    end else if (ctl.start) begin
      inc <= fPreInc; err <= '0;
    end else if (ctl.loadIgn) begin
      inc <= fIgnInc;
    end else if (ctl.sweepInit) begin
      stepQ <= INC_W'(deltaW / divW);
      stepR <= PRE_W'(deltaW % divW);
      err   <= '0;
    end else if (ctl.sweepStep) begin
      inc <= stepInc;
      err <= errNext;
    end
  end

  // phase accumulator and half-period slot counter
  assign accNext = acc + ACC_W'(inc);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc <= '0; halfCnt <= '0;
    end else if (ctl.start) begin
      acc <= '0; halfCnt <= '0;
    end else if (ctl.oscOn) begin
      acc <= accNext;
      if (accNext[ACC_W-1] != acc[ACC_W-1]) halfCnt <= '0;
      else if (halfCnt != {DEAD_W{1'b1}}) halfCnt <= halfCnt + 1'b1;
    end
  end

  logic conduct;
  assign conduct  = ctl.oscOn && (halfCnt >= deadLen);
  assign lowGate  = conduct && !acc[ACC_W-1];
  assign highGate = conduct && acc[ACC_W-1];

  // R3: frequency word stays between ignition and preheat values
  a_r3_inc_range: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.oscOn && fIgnInc < fPreInc) |-> (inc >= fIgnInc && inc <= fPreInc));
  // R10: a gate only rises after a cycle with the other one off
  a_r10_dead_before_high: assert property (@(posedge clk) disable iff (!rstN)
    (deadLen != '0 && $rose(highGate)) |-> !$past(lowGate));
  a_r10_dead_before_low: assert property (@(posedge clk) disable iff (!rstN)
    (deadLen != '0 && $rose(lowGate)) |-> !$past(highGate));
endmodule

// File: rtl/ballast_seq.sv
module ballast_seq
  import ballast_pkg::*;
#(
  parameter int SUP_W    = 8,
  parameter int PRE_W    = 20,
  parameter int ACC_W    = 16,
  parameter int INC_W    = 16,
  parameter int DEAD_W   = 8,
  parameter int MIN_HIGH = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              faultIn,
  input  logic              restartIn,
  input  logic [SUP_W-1:0]  supCode,
  input  logic [SUP_W-1:0]  supOnTh,
  input  logic [SUP_W-1:0]  supOffTh,
  input  logic [PRE_W-1:0]  preLen,
  input  logic [INC_W-1:0]  fPreInc,
  input  logic [INC_W-1:0]  fIgnInc,
  input  logic [DEAD_W-1:0] deadLen,
  output logic              lowGate,
  output logic              highGate,
  output logic [2:0]        phase
);
  osc_ctl_t ctl;
  logic [PRE_W-1:0] shLen;
  phase_t phaseInt;

  ballast_ctrl #(.SUP_W(SUP_W), .PRE_W(PRE_W), .MIN_HIGH(MIN_HIGH)) u_ctrl (
    .clk(clk), .rstN(rstN), .faultIn(faultIn), .restartIn(restartIn),
    .supCode(supCode), .supOnTh(supOnTh), .supOffTh(supOffTh),
    .preLen(preLen), .ctl(ctl), .shLen(shLen), .phase(phaseInt));

  ballast_osc #(.ACC_W(ACC_W), .INC_W(INC_W), .PRE_W(PRE_W), .DEAD_W(DEAD_W)) u_osc (
    .clk(clk), .rstN(rstN), .ctl(ctl), .fPreInc(fPreInc), .fIgnInc(fIgnInc),
    .deadLen(deadLen), .shLen(shLen), .lowGate(lowGate), .highGate(highGate));

  assign phase = phaseInt;

  // R6: fault and off keep both gates low
  a_r6_quiet_when_down: assert property (@(posedge clk) disable iff (!rstN)
    (phaseInt == PH_FAULT || phaseInt == PH_OFF) |-> (!lowGate && !highGate));
  // R5: supply below turn-off threshold forces off next cycle
  a_r5_uv_off: assert property (@(posedge clk) disable iff (!rstN)
    (supCode < supOffTh) |=> phaseInt == PH_OFF);
  // R6: fault is latched without restart or supply drop
  a_r6_fault_hold: assert property (@(posedge clk) disable iff (!rstN)
    (phaseInt == PH_FAULT && !restartIn && supCode >= supOffTh) |=> phaseInt == PH_FAULT);
endmodule

// File: tb/sim_ballast_seq.sv
module sim_ballast_seq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic faultIn = 1'b0, restartIn = 1'b0;
  logic [7:0] supCode = 8'd0, supOnTh = 8'd160, supOffTh = 8'd125;
  logic [11:0] preLen = 12'd200;
  logic [9:0] fPreInc = 10'd64, fIgnInc = 10'd32;
  logic [3:0] deadLen = 4'd2;
  logic lowGate, highGate;
  logic [2:0] phase;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  ballast_seq #(.SUP_W(8), .PRE_W(12), .ACC_W(10), .INC_W(10), .DEAD_W(4), .MIN_HIGH(20)) u0 (
    .clk(clk), .rstN(rstN), .faultIn(faultIn), .restartIn(restartIn),
    .supCode(supCode), .supOnTh(supOnTh), .supOffTh(supOffTh), .preLen(preLen),
    .fPreInc(fPreInc), .fIgnInc(fIgnInc), .deadLen(deadLen),
    .lowGate(lowGate), .highGate(highGate), .phase(phase));

  // passive monitor: phase run lengths, entries, overlap, first gate after start
  int lastLen [0:7];
  int entries [0:7];
  int curLen = 0;
  logic [2:0] curPh = 3'd0;
  int overlap = 0, startSeen = 0, firstHigh = 0;
  logic waitFirst = 1'b0;
  initial for (int i = 0; i < 8; i++) begin lastLen[i] = 0; entries[i] = 0; end

  always @(negedge clk) if (rstN) begin
    if (lowGate && highGate) overlap++;
    if (phase == curPh) curLen++;
    else begin
      lastLen[curPh] = curLen;
      curPh = phase;
      curLen = 1;
      entries[phase]++;
      if (phase == 3'd1) begin waitFirst = 1'b1; startSeen++; end
    end
    if (waitFirst && (lowGate || highGate)) begin
      if (highGate) firstHigh++;
      waitFirst = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitPhase(input logic [2:0] ph, input int limit, input string req);
    int n = 0;
    while (phase != ph && n < limit) begin @(negedge clk); n++; end
    chk(phase == ph, req, phase, ph);
  endtask

  task automatic measureLow(output int per, output int hi);
    logic prev;
    prev = lowGate;
    forever begin @(negedge clk); if (!prev && lowGate) break; prev = lowGate; end
    per = 0; hi = 0; prev = lowGate;
    forever begin
      if (lowGate) hi++;
      per++;
      @(negedge clk);
      if (!prev && lowGate) break;
      prev = lowGate;
    end
  endtask

  task automatic pulse(input bit isFault, input int len);
    if (isFault) faultIn = 1'b1; else restartIn = 1'b1;
    repeat (len) @(negedge clk);
    faultIn = 1'b0; restartIn = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(phase == 3'd0, "R1 phase off after reset", phase, 0);
    chk(!lowGate && !highGate, "R1 gates low after reset", {lowGate, highGate}, 0);
    supCode = 8'd140;   // between thresholds, never valid yet
    repeat (50) @(negedge clk);
    chk(phase == 3'd0, "R5 mid code from off stays off", phase, 0);
  endtask

  task automatic t_startup;
    int per, hi;
    supCode = 8'd200;
    waitPhase(3'd1, 10, "R2 enter preheat");
    measureLow(per, hi);
    chk(per == 16, "R2 preheat period", per, 16);
    chk(hi == 6, "R10 preheat low conduction", hi, 6);
    waitPhase(3'd3, 400, "R4 reach run");
    @(negedge clk);
    chk(lastLen[1] == 200, "R2 preheat length", lastLen[1], 200);
    chk(lastLen[2] == 20, "R3 shift length", lastLen[2], 20);
    measureLow(per, hi);
    chk(per == 32, "R4 run period", per, 32);
    chk(hi == 14, "R10 run low conduction", hi, 14);
  endtask

  task automatic t_short_pulse;
    int per, hi;
    pulse(1'b1, 10);
    repeat (3) @(negedge clk);
    chk(phase == 3'd3, "R9 short fault pulse ignored", phase, 3);
    measureLow(per, hi);
    chk(per == 32, "R9 gates still switching", per, 32);
  endtask

  task automatic t_restart_run;
    int shiftBefore;
    pulse(1'b0, 25);
    repeat (2) @(negedge clk);
    chk(phase == 3'd1, "R8 restart from run", phase, 1);
    waitPhase(3'd3, 400, "R8 sequence completes");
    preLen = 12'd9;
    shiftBefore = entries[2];
    pulse(1'b0, 25);
    waitPhase(3'd3, 60, "R3 skip shift reaches run");
    @(negedge clk);
    chk(lastLen[1] == 9, "R2 short preheat length", lastLen[1], 9);
    chk(entries[2] == shiftBefore, "R3 shift skipped", entries[2], shiftBefore);
    preLen = 12'd200;
  endtask

  task automatic t_fault_restart;
    int on = 0;
    pulse(1'b1, 25);
    @(negedge clk);
    chk(phase == 3'd4, "R6 fault entered", phase, 4);
    repeat (100) begin @(negedge clk); if (lowGate || highGate) on++; end
    chk(on == 0, "R6 gates low in fault", on, 0);
    chk(phase == 3'd4, "R6 fault latched", phase, 4);
    faultIn = 1'b1; restartIn = 1'b1;     // simultaneous: fault wins
    repeat (25) @(negedge clk);
    faultIn = 1'b0; restartIn = 1'b0;
    @(negedge clk);
    chk(phase == 3'd4, "R7 fault wins over restart", phase, 4);
    pulse(1'b0, 25);
    repeat (2) @(negedge clk);
    chk(phase == 3'd1, "R7 restart leaves fault", phase, 1);
  endtask

  task automatic t_fault_supply;
    pulse(1'b1, 25);
    @(negedge clk);
    chk(phase == 3'd4, "R6 fault in preheat", phase, 4);
    supCode = 8'd140;
    repeat (20) @(negedge clk);
    chk(phase == 3'd4, "R5 mid code keeps fault", phase, 4);
    supCode = 8'd100;
    repeat (2) @(negedge clk);
    chk(phase == 3'd0, "R5 below off threshold", phase, 0);
    supCode = 8'd140;
    repeat (20) @(negedge clk);
    chk(phase == 3'd0, "R5 hysteresis holds off", phase, 0);
    supCode = 8'd200;
    repeat (2) @(negedge clk);
    chk(phase == 3'd1, "R7 supply cycle restarts", phase, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_startup();
    t_short_pulse();
    t_restart_run();
    t_fault_restart();
    t_fault_supply();
    waitPhase(3'd3, 400, "R4 final run");
    chk(overlap == 0, "R10 no gate overlap", overlap, 0);
    chk(firstHigh == 0, "R11 low gate first after start", firstHigh, 0);
    chk(startSeen >= 5, "R11 starts observed", startSeen, 5);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule